// File: doc/BRIEF.md
# Multi-Threshold Pulse Timing Coder

This block sits behind a ladder of parallel voltage comparators. All of them watch the same photomultiplier pulse, each at a higher threshold than the one below it. The comparator outputs arrive as one parallel bit vector per clock, and each clock period is one fine-time bin. The coder opens one hit window when the lowest threshold rises. Inside that window it notes, for every threshold, the bin in which that threshold first rose and how many bins it stayed high. When every comparator is low again, or when the window has run for its maximum length, the coder emits one record for the pulse.

Each record holds several fields. A coarse timestamp marks the opening bin, and a bitmask shows which thresholds fired. The edge offsets and time-over-threshold values of the fired thresholds are packed densely in ascending threshold order, so unfired thresholds take no slot. A waveform flag marks pulses whose lowest-threshold duration exceeds a programmable limit, such as the long pulses produced by multi-particle bundles. A pile-up flag marks a second lowest-threshold rise that arrives while the window is still open.

Records leave through a valid/ready port backed by a single output register. A record that completes while that register is still held by a stalled consumer is discarded, and a saturating counter counts the loss.

Top module: `tot_coder`

## Requirements
- R1: A window opens in the cycle where threshold 0 is sampled high after having been sampled low while no window is open. The record timestamp equals a free-running counter's value in that opening cycle. The counter is 0 in the first cycle after reset is released and advances by one each clock.
- R2: For each threshold, the edge offset is the number of cycles from the opening cycle to the cycle in which that threshold first rises inside the window. Threshold 0 therefore has offset 0.
- R3: The time-over-threshold of a threshold is the number of consecutive high samples that begin at its first rise inside the window. Later pulses on the same threshold within that window are not counted, and the value saturates at 255.
- R4: The window closes in the first open cycle in which all comparator bits are sampled low. The record is presented on the output in the next cycle.
- R5: If a window is still open MAX_WIN-1 cycles after its opening cycle, it closes in that cycle. Threshold 0's value then equals MAX_WIN-1. No new window opens until threshold 0 falls and rises again.
- R6: Bit i of the record mask is 1 exactly when threshold i fired in the window. Packed slot k occupies bits [8k+7:8k] of the edge field and of the TOT field, and holds the k-th fired threshold counted upward from threshold 0. Slots beyond the number of fired thresholds are zero.
- R7: The waveform flag is 1 exactly when threshold 0's TOT is strictly greater than the limit input.
- R8: A rise of threshold 0 in a cycle where a window is already open sets the record's pile-up flag and does not start another record.
- R9: While valid is high and ready is low, valid stays high and every record field stays unchanged. A record is consumed in a cycle where valid and ready are both high.
- R10: A record that completes while an unconsumed record is held and ready is low is discarded. The drop counter then increments by one and saturates at its maximum, and the held record is delivered unchanged later.
- R11: During and right after reset, valid is low and the drop counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, one fine-time bin per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| disc_i | input | NTHR | Sampled comparator outputs, bit 0 is the lowest threshold |
| wf_limit_i | input | 8 | Waveform limit compared with threshold 0's TOT |
| rec_ready_i | input | 1 | Consumer accepts the record |
| rec_valid_o | output | 1 | A record is presented |
| rec_ts_o | output | TS_W | Coarse timestamp of the opening cycle |
| rec_mask_o | output | NTHR | Fired-threshold bitmask |
| rec_edge_o | output | NTHR*8 | Packed edge offsets, 8 bits per slot |
| rec_tot_o | output | NTHR*8 | Packed TOT values, 8 bits per slot |
| rec_wf_o | output | 1 | Waveform-candidate flag |
| rec_pile_o | output | 1 | Pile-up flag |
| drop_cnt_o | output | DROP_W | Count of records discarded on stall |

## Verification
The main function is tried with several pulse shapes, and each one separates a different fault. A lone lowest-threshold pulse isolates timestamp and duration counting. Fully nested ladders with staggered rises check that edge offsets are measured against the opening bin. A ladder with a missing middle threshold shows whether packing compacts the slots or leaves the empty slot in place. Pulses at, below and above the waveform limit separate a strict comparison from an inclusive one. A dip-and-rise pattern on the lowest threshold under a still-high upper one checks the pile-up flag, confirms that only the first pulse is timed, and confirms that no extra record appears. Separate sequences hold threshold 0 high past the timeout and stall the consumer through a second pulse, which checks closing on the limit and the drop path.

// File: rtl/tot_pkg.sv
// Shared definitions for the multi-threshold pulse timing coder.
// Assumes every time quantity (edge offset, duration) fits one 8-bit tick field.
package tot_pkg;
    localparam int TICK_W = 8;
    typedef logic [TICK_W-1:0] tick_t;
endpackage

// File: rtl/tot_chan.sv
// One threshold's measurement cell.
// It records the first in-window rising edge of its comparator bit as an offset
// from the window opening, then counts the high samples of that first pulse.
// Assumes start_i and open_i never coincide and rel_i is 0 in the opening cycle.
module tot_chan
    import tot_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    input  logic  open_i,
    input  tick_t rel_i,
    input  logic  lvl_i,
    input  logic  rise_i,
    output logic  fired_o,
    output tick_t edge_o,
    output tick_t tot_o
);
    localparam tick_t TOT_MAX = '1;

    logic  fired_q;
    logic  run_q;
    tick_t edge_q;
    tick_t tot_q;

    // Capture the first edge, then extend the duration while the bit stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fired_q <= 1'b0;
            run_q   <= 1'b0;
            edge_q  <= '0;
            tot_q   <= '0;
        end else if (start_i) begin
            fired_q <= rise_i;
            run_q   <= rise_i;
            edge_q  <= '0;
            tot_q   <= rise_i ? tick_t'(1) : '0;
        end else if (open_i) begin
            if (rise_i && !fired_q) begin
                fired_q <= 1'b1;
                run_q   <= 1'b1;
                edge_q  <= rel_i;
                tot_q   <= tick_t'(1);
            end else if (run_q) begin
                if (!lvl_i)
                    run_q <= 1'b0;
                else if (tot_q != TOT_MAX)
                    tot_q <= tot_q + 1'b1;
            end
        end
    end

    assign fired_o = fired_q;
    assign edge_o  = edge_q;
    assign tot_o   = tot_q;

    AST_FIRED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start_i) && $past(fired_q) && $past(rst_n)) |-> fired_q); // R6

    AST_EDGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (open_i && fired_q) |-> (edge_q <= rel_i)); // R2

    AST_TOT_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (open_i && !start_i && run_q && lvl_i && tot_q != TOT_MAX) |=> (tot_q == $past(tot_q) + 1'b1)); // R3
endmodule

// File: rtl/tot_packer.sv
// Zero-suppression packer.
// It moves the edge and duration of each fired threshold into consecutive slots,
// lowest threshold first, and fills the remaining slots with zero.
// It is purely combinational and assumes the mask marks the valid entries.
module tot_packer #(
    parameter int N  = 8,
    parameter int TW = 8
) (
    input  logic [N-1:0]    mask_i,
    input  logic [N*TW-1:0] edge_i,
    input  logic [N*TW-1:0] tot_i,
    output logic [N*TW-1:0] edge_o,
    output logic [N*TW-1:0] tot_o
);
    localparam int IDX_W = $clog2(N + 1);

    logic [IDX_W-1:0] pre [N];

    // Prefix count: number of fired thresholds below each index.
    always_comb begin
        pre[0] = '0;
        for (int i = 1; i < N; i++)
            pre[i] = pre[i-1] + IDX_W'(mask_i[i-1]);
    end

    // Slot selection: slot k takes the fired entry whose prefix count is k.
    always_comb begin
        edge_o = '0;
        tot_o  = '0;
        for (int k = 0; k < N; k++) begin
            for (int i = 0; i < N; i++) begin
                if (mask_i[i] && pre[i] == IDX_W'(k)) begin
                    edge_o[k*TW +: TW] = edge_i[i*TW +: TW];
                    tot_o[k*TW +: TW]  = tot_i[i*TW +: TW];
                end
            end
        end
    end

    // Unused tail slots must read zero.
    always_comb begin
        for (int k = 0; k < N; k++) begin
            if (k >= $countones(mask_i))
                AST_PACK_TAIL: assert (edge_o[k*TW +: TW] == '0 && tot_o[k*TW +: TW] == '0); // R6
        end
    end
endmodule

// File: rtl/tot_outq.sv
// Single-entry output register with valid/ready handshake.
// A load request that meets a held, unaccepted record is discarded and counted.
// Assumes load_i is a one-cycle pulse per completed record.
module tot_outq #(
    parameter int W     = 64,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [W-1:0]     data_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [W-1:0]     data_o,
    output logic [CNT_W-1:0] drop_o
);
    localparam logic [CNT_W-1:0] DROP_MAX = '1;

    logic             valid_q;
    logic [W-1:0]     data_q;
    logic [CNT_W-1:0] drop_q;
    logic             slot_free;

    assign slot_free = !valid_q || ready_i;

    // Hold, replace or release the presented record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (load_i && slot_free) begin
            valid_q <= 1'b1;
            data_q  <= data_i;
        end else if (ready_i) begin
            valid_q <= 1'b0;
        end
    end

    // Count records lost because the consumer stalled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drop_q <= '0;
        else if (load_i && !slot_free && drop_q != DROP_MAX)
            drop_q <= drop_q + 1'b1;
    end

    assign valid_o = valid_q;
    assign data_o  = data_q;
    assign drop_o  = drop_q;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !ready_i) |=> (valid_q && $stable(data_q))); // R9

    AST_DROP_ONLY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_q != $past(drop_q) && $past(rst_n)) |-> ($past(valid_q) && !$past(ready_i))); // R10
endmodule

// File: rtl/tot_coder.sv
// Multi-threshold pulse timing coder (top).
// It opens one hit window on a rise of threshold 0, runs one measurement cell per
// threshold, closes the window when all comparators are low or on timeout, and
// hands a zero-suppressed record to the output register.
// Assumes disc_i is already synchronous to clk and thresholds are ordered low to high.
module tot_coder
    import tot_pkg::*;
#(
    parameter int NTHR    = 8,
    parameter int TS_W    = 24,
    parameter int MAX_WIN = 200,
    parameter int DROP_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NTHR-1:0]        disc_i,
    input  logic [TICK_W-1:0]      wf_limit_i,
    input  logic                   rec_ready_i,
    output logic                   rec_valid_o,
    output logic [TS_W-1:0]        rec_ts_o,
    output logic [NTHR-1:0]        rec_mask_o,
    output logic [NTHR*TICK_W-1:0] rec_edge_o,
    output logic [NTHR*TICK_W-1:0] rec_tot_o,
    output logic                   rec_wf_o,
    output logic                   rec_pile_o,
    output logic [DROP_W-1:0]      drop_cnt_o
);
    localparam int    FLAT_W  = NTHR * TICK_W;
    localparam int    PAY_W   = TS_W + NTHR + 2 * FLAT_W + 2;
    localparam tick_t WIN_END = tick_t'(MAX_WIN - 1);

    logic [NTHR-1:0] prev_q;
    logic [NTHR-1:0] rise;
    logic            win_q;
    tick_t           rel_q;
    tick_t           cur_rel;
    logic [TS_W-1:0] ts_q;
    logic [TS_W-1:0] ts_open_q;
    logic            pile_q;
    logic            start;
    logic            close;

    logic [NTHR-1:0] fired;
    logic [FLAT_W-1:0] edge_raw, tot_raw, edge_pk, tot_pk;
    logic [PAY_W-1:0]  payload, rec_data;
    logic              wf_flag;

    assign rise    = disc_i & ~prev_q;
    assign start   = rise[0] && !win_q;
    assign close   = win_q && ((disc_i == '0) || (rel_q == WIN_END));
    assign cur_rel = win_q ? rel_q : '0;

    // Free-running coarse time and previous-sample register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q   <= '0;
            prev_q <= '0;
        end else begin
            ts_q   <= ts_q + 1'b1;
            prev_q <= disc_i;
        end
    end

    // Window control: open, age, close, and pile-up marking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q     <= 1'b0;
            rel_q     <= '0;
            ts_open_q <= '0;
            pile_q    <= 1'b0;
        end else if (start) begin
            win_q     <= 1'b1;
            rel_q     <= tick_t'(1);
            ts_open_q <= ts_q;
            pile_q    <= 1'b0;
        end else if (close) begin
            win_q <= 1'b0;
        end else if (win_q) begin
            rel_q <= rel_q + 1'b1;
            if (rise[0])
                pile_q <= 1'b1;
        end
    end

    for (genvar gi = 0; gi < NTHR; gi++) begin : g_chan
        tot_chan i_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (start),
            .open_i  (win_q),
            .rel_i   (cur_rel),
            .lvl_i   (disc_i[gi]),
            .rise_i  (rise[gi]),
            .fired_o (fired[gi]),
            .edge_o  (edge_raw[gi*TICK_W +: TICK_W]),
            .tot_o   (tot_raw[gi*TICK_W +: TICK_W])
        );
    end

    tot_packer #(.N(NTHR), .TW(TICK_W)) i_pack (
        .mask_i (fired),
        .edge_i (edge_raw),
        .tot_i  (tot_raw),
        .edge_o (edge_pk),
        .tot_o  (tot_pk)
    );

    assign wf_flag = tot_raw[TICK_W-1:0] > wf_limit_i;
    assign payload = {ts_open_q, fired, edge_pk, tot_pk, wf_flag, pile_q};

    tot_outq #(.W(PAY_W), .CNT_W(DROP_W)) i_outq (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (close),
        .data_i  (payload),
        .ready_i (rec_ready_i),
        .valid_o (rec_valid_o),
        .data_o  (rec_data),
        .drop_o  (drop_cnt_o)
    );

    assign {rec_ts_o, rec_mask_o, rec_edge_o, rec_tot_o, rec_wf_o, rec_pile_o} = rec_data;

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        win_q |-> (rel_q <= WIN_END)); // R5

    AST_REC_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rec_valid_o) && $past(rst_n)) |-> ($past(win_q) && !win_q)); // R4

    AST_PILE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pile_q) && $past(rst_n)) |-> ($past(win_q) && $past(disc_i[0]))); // R8

    AST_WF_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rec_valid_o) && rec_wf_o && $past(rst_n)) |-> (rec_tot_o[TICK_W-1:0] > $past(wf_limit_i))); // R7
endmodule

// File: tb/test_tot_coder.sv
module test_tot_coder;
    localparam int NT  = 4;
    localparam int MW  = 48;
    localparam int LIM = 20;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [3:0]   disc;
    logic [7:0]   limit;
    logic         ready;
    logic         valid;
    logic [23:0]  ts;
    logic [3:0]   mask;
    logic [31:0]  edg;
    logic [31:0]  tot;
    logic         wf;
    logic         pile;
    logic [15:0]  drops;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    tot_coder #(.NTHR(NT), .TS_W(24), .MAX_WIN(MW), .DROP_W(16)) i_tot_coder (
        .clk         (clk),
        .rst_n       (rst_n),
        .disc_i      (disc),
        .wf_limit_i  (limit),
        .rec_ready_i (ready),
        .rec_valid_o (valid),
        .rec_ts_o    (ts),
        .rec_mask_o  (mask),
        .rec_edge_o  (edg),
        .rec_tot_o   (tot),
        .rec_wf_o    (wf),
        .rec_pile_o  (pile),
        .drop_cnt_o  (drops)
    );

    typedef struct packed {
        logic [31:0] st;
        logic [31:0] ln;
        logic [3:0]  mk;
        logic [31:0] ed;
        logic [31:0] tt;
        logic        wf;
    } vec_t;

    // Per-threshold start/length (byte i = threshold i), expected mask, packed slots, flag.
    localparam vec_t VECS [6] = '{
        '{32'h00000000, 32'h00000003, 4'b0001, 32'h00000000, 32'h00000003, 1'b0},
        '{32'h00040200, 32'h0002060A, 4'b0111, 32'h00040200, 32'h0002060A, 1'b0},
        '{32'h03000100, 32'h05000A0C, 4'b1011, 32'h00030100, 32'h00050A0C, 1'b0},
        '{32'h00000500, 32'h0000031E, 4'b0011, 32'h00000500, 32'h0000031E, 1'b1},
        '{32'h03020100, 32'h09121619, 4'b1111, 32'h03020100, 32'h09121619, 1'b1},
        '{32'h00000000, 32'h00000014, 4'b0001, 32'h00000000, 32'h00000014, 1'b0}
    };

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            disc = '0;
        end
    endtask

    // Play one table pulse and check the resulting record.
    task automatic run_vec(input int v);
        int t_end = 0;
        int stamp = 0;
        vec_t e = VECS[v];
        for (int i = 0; i < NT; i++)
            if (e.ln[i*8 +: 8] != 0 && int'(e.st[i*8 +: 8]) + int'(e.ln[i*8 +: 8]) > t_end)
                t_end = int'(e.st[i*8 +: 8]) + int'(e.ln[i*8 +: 8]);
        for (int t = 0; t < t_end; t++) begin
            @(negedge clk);
            if (t == 0) stamp = cyc;
            for (int i = 0; i < NT; i++)
                disc[i] = (e.ln[i*8 +: 8] != 0) && (t >= int'(e.st[i*8 +: 8])) &&
                          (t < int'(e.st[i*8 +: 8]) + int'(e.ln[i*8 +: 8]));
        end
        @(negedge clk);
        disc = '0;
        @(negedge clk);
        chk("R4", $sformatf("vec%0d valid one cycle after all low", v), 64'(valid), 64'd1);
        chk("R1", $sformatf("vec%0d timestamp", v), 64'(ts), 64'(stamp));
        chk("R6", $sformatf("vec%0d mask", v), 64'(mask), 64'(e.mk));
        chk("R2", $sformatf("vec%0d packed edges", v), 64'(edg), 64'(e.ed));
        chk("R3", $sformatf("vec%0d packed tots", v), 64'(tot), 64'(e.tt));
        chk("R7", $sformatf("vec%0d waveform flag", v), 64'(wf), 64'(e.wf));
        chk("R8", $sformatf("vec%0d no pile-up", v), 64'(pile), 64'd0);
        @(negedge clk);
        chk("R9", $sformatf("vec%0d consumed when ready", v), 64'(valid), 64'd0);
        idle(2);
    endtask

    initial begin
        int stamp;
        int first;
        int nval;
        logic [7:0] t0;
        logic       wf0;
        logic [23:0] ts0;

        rst_n = 1'b0;
        disc  = '0;
        limit = 8'(LIM);
        ready = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11", "valid in reset", 64'(valid), 64'd0);
        chk("R11", "drop counter in reset", 64'(drops), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "valid after reset", 64'(valid), 64'd0);
        idle(2);

        // Table-driven main function.
        for (int v = 0; v < 6; v++)
            run_vec(v);

        // R8: threshold 0 dips and rises while threshold 1 holds the window open.
        begin
            logic [3:0] pat [9] = '{4'b0001, 4'b0011, 4'b0011, 4'b0011, 4'b0010,
                                    4'b0011, 4'b0011, 4'b0010, 4'b0000};
            for (int t = 0; t < 9; t++) begin
                @(negedge clk);
                if (t == 0) stamp = cyc;
                disc = pat[t];
            end
            @(negedge clk);
            chk("R8", "pile-up record valid", 64'(valid), 64'd1);
            chk("R8", "pile-up flag", 64'(pile), 64'd1);
            chk("R1", "pile-up timestamp", 64'(ts), 64'(stamp));
            chk("R6", "pile-up mask", 64'(mask), 64'b0011);
            chk("R2", "pile-up edges", 64'(edg), 64'h0000_0100);
            chk("R3", "pile-up first pulse only", 64'(tot), 64'h0000_0704);
            nval = 0;
            for (int j = 0; j < 6; j++) begin
                @(negedge clk);
                if (valid) nval++;
            end
            chk("R8", "no second record", 64'(nval), 64'd0);
        end

        // R5: threshold 0 held high past the window limit.
        first = -1;
        nval = 0;
        t0 = '0; wf0 = 1'b0; ts0 = '0;
        for (int t = 0; t < 60; t++) begin
            @(negedge clk);
            if (t == 0) stamp = cyc;
            if (valid) begin
                nval++;
                if (first < 0) begin
                    first = t;
                    t0 = tot[7:0];
                    wf0 = wf;
                    ts0 = ts;
                end
            end
            disc = 4'b0001;
        end
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            disc = '0;
            if (valid) nval++;
        end
        chk("R5", "timeout record cycle", 64'(first), 64'(MW));
        chk("R5", "timeout tot0", 64'(t0), 64'(MW - 1));
        chk("R7", "timeout waveform flag", 64'(wf0), 64'd1);
        chk("R1", "timeout timestamp", 64'(ts0), 64'(stamp));
        chk("R5", "single record for held pulse", 64'(nval), 64'd1);

        // R9/R10: stalled consumer, second pulse discarded.
        @(negedge clk);
        ready = 1'b0;
        stamp = cyc;
        disc = 4'b0001;
        @(negedge clk); disc = 4'b0001;
        @(negedge clk); disc = 4'b0001;
        @(negedge clk); disc = 4'b0000;
        @(negedge clk);
        @(negedge clk);
        chk("R9", "held valid under stall", 64'(valid), 64'd1);
        chk("R9", "held timestamp under stall", 64'(ts), 64'(stamp));
        disc = 4'b0001;
        @(negedge clk); disc = 4'b0001;
        @(negedge clk); disc = 4'b0000;
        @(negedge clk);
        @(negedge clk);
        chk("R10", "drop counter", 64'(drops), 64'd1);
        chk("R10", "held record still valid", 64'(valid), 64'd1);
        chk("R10", "held record timestamp kept", 64'(ts), 64'(stamp));
        chk("R10", "held record tot kept", 64'(tot), 64'd3);
        ready = 1'b1;
        @(negedge clk);
        chk("R9", "released on ready", 64'(valid), 64'd0);
        nval = 0;
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            if (valid) nval++;
        end
        chk("R10", "dropped record never delivered", 64'(nval), 64'd0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL R4 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule